// File: doc/BRIEF.md
# Prescaled Reload Timer

A programmable down-counting timer for a 13.56 MHz digital core. A 12-bit prescale setting N makes a tick every 2·N+1 core clocks. Each tick decrements a 16-bit counter. The counter is loaded from a software reload value when the timer is started. When a tick finds the counter at one (or at zero), the timer expires and sets a sticky interrupt flag. It then either reloads and carries on (auto-restart) or stops (single-shot). This lets one unit serve as a timeout, a watchdog, a periodic tick or a stopwatch.

An optional gated mode makes both the prescaler and the counter advance only while an external gate input is high. The running status stays set while the gate is low and the count is held. Software reaches the timer through an 8-bit register port with write and read strobes. A read of the low count byte captures the high byte, so a two-byte read returns one consistent value.

Top module: `reload_timer`

## Requirements
- R1: After synchronous reset, all eight registers read 0x00 and `irq` is low.
- R2: While the timer is running and not held by the gate, the prescaler ticks every 2·N+1 clocks, and every tick decrements the counter by one. A one-shot start with reload R expires exactly R·(2·N+1) clocks after the start write, up to R = 65535. N = 0 ticks every clock.
- R3: A start command loads the counter from the reload value, clears the prescaler and sets running, all on the write edge.
- R4: A tick that finds the count at 1 or 0 is an expiry. In single-shot mode an expiry leaves the count at 0 and clears running. Reload 0 expires on the first tick.
- R5: With auto-restart set, an expiry reloads the counter and keeps running, so expiries repeat every R·(2·N+1) clocks.
- R6: A stop command clears running and freezes the count at its value before that edge. When start and stop are written together, stop wins.
- R7: In gated mode the prescaler and counter advance only on clocks where `gate_in` is high. Running stays 1 while the gate is low.
- R8: The interrupt flag drives `irq`. It stays set until a write of 1 to command bit 2. An expiry in the same cycle as a clear leaves the flag set.
- R9: Register map (3-bit address):
  - 0, control (r/w): bit0 auto-restart, bit1 gated mode; other bits read 0.
  - 1, command: on a write, bit0 is start, bit1 stop, bit2 clear flag; a read returns bit0 running and bit1 flag.
  - 2 and 3, prescale low and high: the high register keeps bits 3:0.
  - 4 and 5, reload low and high.
  - 6 and 7, count low and high: read-only, and writes to them are ignored.
- R10: A read of address 6 returns the live low count byte and captures the live high byte. A read of address 7 returns the captured byte.
- R11: A write to the reload registers while running leaves the current count alone. The new value is used at the next start or auto-reload.
- R12: `rdata` is registered: it takes the addressed value on the clock edge where `rd_en` is high and holds on other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| gate_in | input | 1 | External count qualifier for gated mode |
| irq | output | 1 | Sticky expiry flag |

## Verification
The bench builds the block with its default parameters: a 12-bit prescale and a 16-bit counter. With these, the full 65535-tick span at N = 0 and a 339-clock tick at N = 169 both fit in one run. Small settings (N of 0 or 1, reloads of 0 to 20) reach the cycle-exact corners at low cost. These corners are:
- a clear arriving on an expiry edge;
- stop written together with start;
- a reload rewritten mid-count;
- a count read that crosses a byte boundary between its two halves.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRE_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRE_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd6;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd7;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_CLR   = 2;

  typedef struct packed {
    logic gated;
    logic auto_rst;
  } tmr_ctrl_t;
endpackage

// File: rtl/reload_timer_regs.sv
module reload_timer_regs
  import reload_timer_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [CNT_W-1:0]   count,
  input  logic               running,
  input  logic               irq,
  output tmr_ctrl_t          ctrl,
  output logic [PRESC_W-1:0] presc,
  output logic [CNT_W-1:0]   reload,
  output logic               start_p,
  output logic               stop_p,
  output logic               clr_p
);
  localparam int PHI_W = PRESC_W - DATA_W;
  localparam int CHI_W = CNT_W - DATA_W;

  logic [CHI_W-1:0]  cnt_shadow;
  logic [DATA_W-1:0] rd_mux;
  logic              cmd_wr;

  assign cmd_wr  = wr_en && (addr == A_CMD);
  assign start_p = cmd_wr && wdata[CMD_START];
  assign stop_p  = cmd_wr && wdata[CMD_STOP];
  assign clr_p   = cmd_wr && wdata[CMD_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      presc  <= '0;
      reload <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:   ctrl <= tmr_ctrl_t'(wdata[1:0]);
        A_PRE_LO: presc[DATA_W-1:0] <= wdata;
        A_PRE_HI: presc[PRESC_W-1:DATA_W] <= wdata[PHI_W-1:0];
        A_RLD_LO: reload[DATA_W-1:0] <= wdata;
        A_RLD_HI: reload[CNT_W-1:DATA_W] <= wdata[CHI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:   rd_mux = DATA_W'(ctrl);
      A_CMD:    rd_mux = DATA_W'({irq, running});
      A_PRE_LO: rd_mux = presc[DATA_W-1:0];
      A_PRE_HI: rd_mux = DATA_W'(presc[PRESC_W-1:DATA_W]);
      A_RLD_LO: rd_mux = reload[DATA_W-1:0];
      A_RLD_HI: rd_mux = DATA_W'(reload[CNT_W-1:DATA_W]);
      A_CNT_LO: rd_mux = count[DATA_W-1:0];
      default:  rd_mux = DATA_W'(cnt_shadow);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      cnt_shadow <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
      if (addr == A_CNT_LO) cnt_shadow <= count[CNT_W-1:DATA_W];
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R12
  AST_SHADOW_ONLY_ON_LO: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == A_CNT_LO) |=> $stable(cnt_shadow)); // R10
endmodule

// File: rtl/reload_timer_presc.sv
module reload_timer_presc #(
  parameter int PRESC_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] presc,
  input  logic               run,
  input  logic               gated,
  input  logic               gate_in,
  input  logic               clear,
  output logic               tick
);
  localparam int PC_W = PRESC_W + 1;

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] lim;
  logic            advance;
  logic            wrap;

  assign lim     = {presc, 1'b0};
  assign advance = run && (!gated || gate_in);
  assign wrap    = (pcnt >= lim);
  assign tick    = advance && wrap && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pcnt <= '0;
    end else if (advance) begin
      if (wrap) pcnt <= '0;
      else      pcnt <= pcnt + PC_W'(1);
    end
  end

  AST_GATE_HOLDS_PRESC: assert property (@(posedge clk) disable iff (rst)
    (run && gated && !gate_in && !clear) |=> $stable(pcnt)); // R7
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    tick |-> run); // R2
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clear |=> pcnt == '0); // R3
endmodule

// File: rtl/reload_timer_count.sv
module reload_timer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] reload,
  input  logic             auto_rst,
  input  logic             load,
  input  logic             stop,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             irq
);
  logic expire;

  assign expire = tick && running && !stop && !load && (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
    end else if (stop) begin
      running <= 1'b0;
    end else if (load) begin
      count   <= reload;
      running <= 1'b1;
    end else if (tick && running) begin
      if (expire) begin
        if (auto_rst) begin
          count <= reload;
        end else begin
          count   <= '0;
          running <= 1'b0;
        end
      end else begin
        count <= count - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         irq <= 1'b0;
    else if (expire) irq <= 1'b1;
    else if (clr)    irq <= 1'b0;
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
    load && !stop |=> running && count == $past(reload)); // R3
  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (rst)
    expire && !auto_rst |=> !running && count == '0); // R4
  AST_AUTO_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    expire && auto_rst |=> running); // R5
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (rst)
    stop |=> !running && count == $past(count)); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq && !clr |=> irq); // R8
  AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq); // R8
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              gate_in,
  output logic              irq
);
  tmr_ctrl_t          ctrl;
  logic [PRESC_W-1:0] presc;
  logic [CNT_W-1:0]   reload;
  logic [CNT_W-1:0]   count;
  logic               running;
  logic               start_p, stop_p, clr_p;
  logic               load, tick;

  assign load = start_p && !stop_p;

  reload_timer_regs #(.PRESC_W(PRESC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .count(count), .running(running), .irq(irq),
    .ctrl(ctrl), .presc(presc), .reload(reload),
    .start_p(start_p), .stop_p(stop_p), .clr_p(clr_p)
  );

  reload_timer_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .presc(presc), .run(running && !stop_p),
    .gated(ctrl.gated), .gate_in(gate_in), .clear(load), .tick(tick)
  );

  reload_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .reload(reload), .auto_rst(ctrl.auto_rst),
    .load(load), .stop(stop_p), .tick(tick), .clr(clr_p),
    .count(count), .running(running), .irq(irq)
  );

  AST_GATED_RUN_HELD: assert property (@(posedge clk) disable iff (rst)
    running && ctrl.gated && !gate_in && !stop_p |=> running); // R7
endmodule

// File: tb/reload_timer_bench.sv
`timescale 1ns/1ps
module reload_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, gate_in = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  reload_timer u_reload_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gate_in(gate_in), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic setup(input int n, input int r, input logic [7:0] c);
    wr(3'd1, 8'h06);
    wr(3'd0, c);
    wr(3'd2, n[7:0]);
    wr(3'd3, 8'(n >> 8));
    wr(3'd4, r[7:0]);
    wr(3'd5, 8'(r >> 8));
  endtask

  task automatic t_reset;
    check("R1 irq after reset", irq, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 reg %0d after reset", a), v, 0);
    end
  endtask

  task automatic t_regmap;
    wr(3'd3, 8'hFF); rd(3'd3, v); check("R9 prescale high keeps 4 bits", v, 8'h0F);
    wr(3'd0, 8'hFF); rd(3'd0, v); check("R9 control keeps 2 bits", v, 8'h03);
    wr(3'd6, 8'h55); rd(3'd6, v); check("R9 count low ignores write", v, 0);
    wr(3'd7, 8'h55); rd(3'd6, v); rd(3'd7, v); check("R9 count high ignores write", v, 0);
    wr(3'd0, 8'h00); wr(3'd3, 8'h00);
  endtask

  task automatic t_period169;
    setup(169, 3, 8'h00);
    wr(3'd1, 8'h01);
    idle(1016); check("R2 no expiry before 3*339 clocks", irq, 0);
    idle(1);    check("R2 expiry at 3*339 clocks", irq, 1);
    rd(3'd1, v); check("R4 one-shot status flag set running clear", v, 8'h02);
    rd(3'd6, v); check("R4 one-shot count ends at 0", v, 0);
  endtask

  task automatic t_zero_reload;
    setup(0, 0, 8'h00);
    wr(3'd1, 8'h01);
    idle(1); check("R4 reload 0 expires on first tick", irq, 1);
    rd(3'd1, v); check("R4 reload 0 stops", v, 8'h02);
  endtask

  task automatic t_stop;
    setup(0, 10, 8'h00);
    wr(3'd1, 8'h01);
    idle(3);
    wr(3'd1, 8'h02);
    rd(3'd6, v); check("R6 stop freezes count", v, 7);
    rd(3'd1, v); check("R6 stop clears running", v, 0);
    idle(10);
    rd(3'd6, v); check("R6 count stays frozen", v, 7);
    wr(3'd1, 8'h03);
    rd(3'd1, v); check("R6 stop beats start", v, 0);
    rd(3'd6, v); check("R6 stop beats start keeps count", v, 7);
    check("R6 no expiry while stopped", irq, 0);
  endtask

  task automatic t_auto;
    setup(1, 2, 8'h01);
    wr(3'd1, 8'h01);
    idle(5); check("R5 no expiry before 6 clocks", irq, 0);
    idle(1); check("R5 first expiry at 6 clocks", irq, 1);
    wr(3'd1, 8'h04); check("R8 clear drops flag", irq, 0);
    rd(3'd1, v); check("R5 still running after expiry", v, 8'h01);
    idle(3); check("R5 no second expiry early", irq, 0);
    idle(1); check("R5 second expiry 6 clocks later", irq, 1);
    wr(3'd1, 8'h06);
  endtask

  task automatic t_irq_race;
    setup(0, 4, 8'h00);
    wr(3'd1, 8'h01);
    idle(3);
    wr(3'd1, 8'h04);
    check("R8 expiry beats same-cycle clear", irq, 1);
    idle(5); check("R8 flag sticky", irq, 1);
    wr(3'd1, 8'h04);
    check("R8 later clear drops flag", irq, 0);
  endtask

  task automatic t_gate;
    setup(1, 2, 8'h02);
    gate_in = 1'b0;
    wr(3'd1, 8'h01);
    idle(20); check("R7 gate low holds expiry", irq, 0);
    rd(3'd1, v); check("R7 running while gate low", v, 8'h01);
    rd(3'd6, v); check("R7 count held while gate low", v, 2);
    gate_in = 1'b1;
    idle(5); check("R7 no expiry before 6 gated clocks", irq, 0);
    idle(1); check("R7 expiry after 6 gated clocks", irq, 1);
    gate_in = 1'b0;
    wr(3'd1, 8'h06);
  endtask

  task automatic t_reload_live;
    setup(0, 20, 8'h00);
    wr(3'd1, 8'h01);
    idle(2);
    wr(3'd4, 8'd5);
    idle(16); check("R11 reload write leaves count", irq, 0);
    idle(1);  check("R11 expiry keeps old reload", irq, 1);
    wr(3'd1, 8'h04);
    wr(3'd1, 8'h01);
    idle(4); check("R3 new reload no early expiry", irq, 0);
    idle(1); check("R3 start loads new reload 5", irq, 1);
  endtask

  task automatic t_coherent;
    setup(0, 16'h0102, 8'h00);
    wr(3'd1, 8'h01);
    idle(2);
    rd(3'd6, v); check("R10 count low at 0x0100", v, 8'h00);
    rd(3'd7, v); check("R10 captured high byte", v, 8'h01);
    idle(3);
    check("R12 rdata holds without read", rdata, 8'h01);
    wr(3'd1, 8'h06);
  endtask

  task automatic t_span;
    setup(0, 16'hFFFF, 8'h00);
    wr(3'd1, 8'h01);
    idle(65534); check("R2 no expiry before 65535 ticks", irq, 0);
    idle(1);     check("R2 expiry at 65535 ticks", irq, 1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_regmap();
    t_period169();
    t_zero_reload();
    t_stop();
    t_auto();
    t_irq_race();
    t_gate();
    t_reload_live();
    t_coherent();
    t_span();
    finish_run();
  end
endmodule